// File: doc/BRIEF.md
# Alternating Threshold Offset Loader

This block keeps the two 12-bit threshold offsets that a FIFO's flag logic uses. One sets how close to empty the almost-empty flag fires. The other sets how close to full the almost-full flag fires. Both offsets are programmed through the FIFO's shared data input. The access is selected by an active-low load input together with the active-low write enable, on the write clock.

A write-side selection bit alternates between the empty offset and the full offset after every load access. A burst of load cycles therefore writes empty, full, empty and so on. Load mode may be left after any number of accesses. The selection bit keeps its position, so the next load access goes to the other register.

Readback follows the same alternating order. It uses a separate read-side selection bit, the active-low read enable and the read clock. The selected offset appears zero-extended on the output register. When load is high, the write and read enables pass through as ordinary FIFO write and read strobes. The current offsets are always driven to the flag logic.

Top module: `offset_loader`

## Requirements
- R1: An active-low reset sets both offsets to 0x07F and the output register to zero. It also points both selection bits at the empty offset.
- R2: With load_n low and wen_n low, each rising wclk edge writes din[11:0] into the selected offset and advances the write selection. After reset the order is empty, full, empty.
- R3: din bits 17..12 have no effect on the stored offset.
- R4: With load_n low and wen_n high, neither offset changes and the write selection holds.
- R5: With load_n high, neither offset changes and fifo_wr_en equals the inverse of wen_n. The next load access continues with the register after the last one written.
- R6: With load_n low and ren_n low, each rising rclk edge loads the selected offset into dout, zero-extended to bits 17..12. It also advances the read selection, starting from the empty offset.
- R7: With ren_n high or load_n high, dout and the read selection hold. With load_n high, fifo_rd_en equals the inverse of ren_n.
- R8: The read selection does not depend on the write selection. A readback on the same edge as a load write to the same register returns the value from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_n | input | 1 | Active-low offset access select |
| wen_n | input | 1 | Active-low write enable |
| ren_n | input | 1 | Active-low read enable |
| din | input | 18 | Shared data input; bits 11..0 carry an offset |
| dout | output | 18 | Readback output register |
| empty_ofs | output | 12 | Almost-empty offset to flag logic |
| full_ofs | output | 12 | Almost-full offset to flag logic |
| fifo_wr_en | output | 1 | Normal FIFO write strobe |
| fifo_rd_en | output | 1 | Normal FIFO read strobe |

## Verification
Programming and readback can land on the same edge, because the bench drives both clocks from one source. The vector table steers the two selection bits so that one edge carries a load write to the empty offset and a readback of that same register. The result is judged on dout, which must show the old value, and on empty_ofs, which must show the new one. The following readbacks confirm that each selection bit advanced on its own.

// File: rtl/offset_loader.sv
module offset_loader #(
  parameter int DATA_W = 18,
  parameter int OFS_W = 12,
  parameter logic [11:0] OFS_DEFAULT = 12'h07F
) (
  input  logic              wclk,
  input  logic              rclk,
  input  logic              rst_n,
  input  logic              load_n,
  input  logic              wen_n,
  input  logic              ren_n,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  output logic [OFS_W-1:0]  empty_ofs,
  output logic [OFS_W-1:0]  full_ofs,
  output logic              fifo_wr_en,
  output logic              fifo_rd_en
);

  localparam int PAD_W = DATA_W - OFS_W;

  logic wsel, rsel;
  logic ld_wr, ld_rd;

  assign ld_wr = !load_n && !wen_n;
  assign ld_rd = !load_n && !ren_n;
  assign fifo_wr_en = load_n && !wen_n;
  assign fifo_rd_en = load_n && !ren_n;

  always_ff @(posedge wclk or negedge rst_n) begin
    if (!rst_n) begin
      wsel      <= 1'b0;
      empty_ofs <= OFS_DEFAULT[OFS_W-1:0];
      full_ofs  <= OFS_DEFAULT[OFS_W-1:0];
    end else if (ld_wr) begin
      wsel <= !wsel;
      if (wsel) full_ofs  <= din[OFS_W-1:0];
      else      empty_ofs <= din[OFS_W-1:0];
    end
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n) begin
      rsel <= 1'b0;
      dout <= '0;
    end else if (ld_rd) begin
      rsel <= !rsel;
      dout <= {{PAD_W{1'b0}}, (rsel ? full_ofs : empty_ofs)};
    end
  end

  p_alt_r2: assert property (@(posedge wclk) disable iff (!rst_n)
    ld_wr |=> wsel != $past(wsel));
  p_empty_load_r2: assert property (@(posedge wclk) disable iff (!rst_n)
    (ld_wr && !wsel) |=> (empty_ofs == $past(din[OFS_W-1:0])) && $stable(full_ofs));
  p_nop_r4: assert property (@(posedge wclk) disable iff (!rst_n)
    (!load_n && wen_n) |=> $stable(empty_ofs) && $stable(full_ofs) && $stable(wsel));
  p_normal_r5: assert property (@(posedge wclk) disable iff (!rst_n)
    load_n |=> $stable(empty_ofs) && $stable(full_ofs));
  p_zext_r6: assert property (@(posedge rclk) disable iff (!rst_n)
    dout[DATA_W-1:OFS_W] == '0);
  p_rd_hold_r7: assert property (@(posedge rclk) disable iff (!rst_n)
    (ren_n || load_n) |=> $stable(dout) && $stable(rsel));

endmodule

// File: tb/offset_loader_tb_top.sv
module offset_loader_tb_top;
  logic clk = 1'b0;
  logic rst_n, load_n, wen_n, ren_n;
  logic [17:0] din, dout;
  logic [11:0] empty_ofs, full_ofs;
  logic fifo_wr_en, fifo_rd_en;
  int checks = 0, errors = 0;

  always #10 clk = !clk;

  offset_loader dut_i (
    .wclk(clk), .rclk(clk), .rst_n(rst_n), .load_n(load_n), .wen_n(wen_n),
    .ren_n(ren_n), .din(din), .dout(dout), .empty_ofs(empty_ofs),
    .full_ofs(full_ofs), .fifo_wr_en(fifo_wr_en), .fifo_rd_en(fifo_rd_en));

  // fields: load_n, wen_n, ren_n, din[18], exp empty[12], exp full[12], exp dout[18]
  localparam int NV = 15;
  localparam logic [62:0] VEC [NV] = '{
    {3'b001, 18'h3F123, 12'h123, 12'h07F, 18'h00000}, // R2 R3 empty first, high bits dropped
    {3'b001, 18'h00456, 12'h123, 12'h456, 18'h00000}, // R2 full second
    {3'b001, 18'h00789, 12'h789, 12'h456, 18'h00000}, // R2 empty third
    {3'b011, 18'h00AAA, 12'h789, 12'h456, 18'h00000}, // R4 no operation
    {3'b101, 18'h00BBB, 12'h789, 12'h456, 18'h00000}, // R5 normal write
    {3'b001, 18'h00CDE, 12'h789, 12'hCDE, 18'h00000}, // R5 resume at full
    {3'b010, 18'h00000, 12'h789, 12'hCDE, 18'h00789}, // R6 read empty
    {3'b010, 18'h00000, 12'h789, 12'hCDE, 18'h00CDE}, // R6 read full
    {3'b011, 18'h00000, 12'h789, 12'hCDE, 18'h00CDE}, // R7 ren high
    {3'b110, 18'h00000, 12'h789, 12'hCDE, 18'h00CDE}, // R7 load high
    {3'b010, 18'h00000, 12'h789, 12'hCDE, 18'h00789}, // R6 read empty again
    {3'b010, 18'h00000, 12'h789, 12'hCDE, 18'h00CDE}, // R6 read full
    {3'b000, 18'h00111, 12'h111, 12'hCDE, 18'h00789}, // R8 same-edge write/read
    {3'b010, 18'h00000, 12'h111, 12'hCDE, 18'h00CDE}, // R8 read full
    {3'b010, 18'h00000, 12'h111, 12'hCDE, 18'h00111}  // R8 read new empty
  };

  function automatic string req_of(int i);
    case (i)
      0, 1, 2: return "R2";
      3: return "R4";
      4, 5: return "R5";
      8, 9: return "R7";
      12, 13, 14: return "R8";
      default: return "R6";
    endcase
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; load_n = 1'b1; wen_n = 1'b1; ren_n = 1'b1; din = '0;
    repeat (2) @(negedge clk);
    check("R1 empty", 32'(empty_ofs), 32'h07F);
    check("R1 full", 32'(full_ofs), 32'h07F);
    check("R1 dout", 32'(dout), 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      {load_n, wen_n, ren_n, din} = VEC[i][62:42];
      @(negedge clk);
      check({req_of(i), " empty"}, 32'(empty_ofs), 32'(VEC[i][41:30]));
      check({req_of(i), " full"}, 32'(full_ofs), 32'(VEC[i][29:18]));
      check({req_of(i), " dout"}, 32'(dout), 32'(VEC[i][17:0]));
    end
    load_n = 1'b1; wen_n = 1'b0; ren_n = 1'b1; #1;
    check("R5 fifo_wr_en", 32'(fifo_wr_en), 32'h1);
    check("R7 fifo_rd_en", 32'(fifo_rd_en), 32'h0);
    ren_n = 1'b0; wen_n = 1'b1; #1;
    check("R7 fifo_rd_en on", 32'(fifo_rd_en), 32'h1);
    check("R5 fifo_wr_en off", 32'(fifo_wr_en), 32'h0);
    load_n = 1'b0; #1;
    check("R5 strobes off in load", 32'({fifo_wr_en, fifo_rd_en}), 32'h0);
    load_n = 1'b1; ren_n = 1'b1;
    @(negedge clk);
    // write selection currently points at full; reset must bring it back to empty
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 reset restores empty", 32'(empty_ofs), 32'h07F);
    check("R1 reset restores full", 32'(full_ofs), 32'h07F);
    rst_n = 1'b1;
    load_n = 1'b0; wen_n = 1'b0; din = 18'h00ABC;
    @(negedge clk);
    check("R1 write selection reset", 32'(empty_ofs), 32'hABC);
    check("R1 full untouched", 32'(full_ofs), 32'h07F);
    wen_n = 1'b1; ren_n = 1'b0;
    @(negedge clk);
    check("R1 read selection reset", 32'(dout), 32'hABC);
    load_n = 1'b1; ren_n = 1'b1;
    @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule